// File: doc/BRIEF.md
# Dual-Bank Edge Interrupt Controller

This block collects 64 peripheral request lines into one active-high interrupt towards a host processor. The lines are split into two banks of 32. Each bank holds three registers: an enable register, a polarity register and a status register. Every raw input passes through a two-flop synchronizer. An edge detector then compares the polarity-adjusted level with its value one cycle earlier. When an enabled line shows an active edge, its pending bit in the status register is set.

Software writes the registers through a single-cycle write strobe and reads them through a combinational read port. A pending bit is cleared by writing a one to it. The host request is the registered OR, over both banks, of the pending bits whose enable is set.

Edge capture happens only while a line is enabled. If the polarity of an enabled line is rewritten so that its adjusted level goes from low to high, the detector sees an edge and latches it.

Top module: `irqc_dual_bank`

## Requirements
- R1: Line i belongs to bank i/32 at bit i%32. The register index is 2*kind + bank: kind 0 is enable, kind 1 is polarity and kind 2 is status. This gives index 0 enable-low, 1 enable-high, 2 polarity-low, 3 polarity-high, 4 status-low and 5 status-high. Reads of indexes 6 and 7 return 0.
- R2: After reset, all six registers read 0 and `host_irq` is 0.
- R3: A polarity bit of 0 captures rising edges and a polarity bit of 1 captures falling edges. A change on `irq_lines` driven before rising clock edge 1 shows in status after edge 3 and not after edge 2.
- R4: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: While a line's enable bit is 0, edges on that line are not captured and are not kept for later.
- R6: Rewriting the polarity of an enabled line sets its pending bit when the adjusted level (line XOR polarity) goes from 0 to 1. This happens for a low line moved from polarity 0 to 1, or a high line moved from 1 to 0. The opposite change sets nothing.
- R7: If a captured edge and a write-one-to-clear hit the same bit in the same cycle, the bit stays pending.
- R8: `host_irq` equals the OR over both banks of (status AND enable), delayed by one clock.
- R9: A pending bit of a disabled line stays readable in status but does not raise `host_irq`.
- R10: Enabling a line whose level is already at its active level does not set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Raw peripheral request lines, asynchronous |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| host_irq | output | 1 | Registered active-high request to the host |

## Verification
The assertions check on every cycle the properties that hold at each clock edge:
- no pending bit appears without a captured edge on an enabled line;
- a captured edge always leaves its bit pending, even against a clear;
- a clear removes every written bit that had no new edge;
- the host request tracks the enabled pending bits one cycle later.

Some behaviours need stimulus that only the bench's scenarios supply. These are the polarity selection, the three-cycle input latency, edges lost while a line is disabled, the pending bit latched by a polarity rewrite, enabling a line at its active level, and the readback of a disabled pending bit. The bench compares these against a bit-level model of line level, enable, polarity and pending state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      KIND_ENABLE   = 2'd0,
      KIND_POLARITY = 2'd1,
      KIND_STATUS   = 2'd2
   } reg_kind_e;

   localparam int NUM_KINDS = 3;

   function automatic int reg_index(reg_kind_e kind, int bank, int nbanks);
      return int'(kind) * nbanks + bank;
   endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= async_in;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_s,
   input  logic         wr_en_sel,
   input  logic         wr_pol_sel,
   input  logic         wr_clr_sel,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] en_q,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] stat_q,
   output logic         req
);
   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("irqc_bank: W must be 1..32");
      end
   endgenerate

   logic [W-1:0] adj;
   logic [W-1:0] prev_q;
   logic [W-1:0] edge_v;
   logic [W-1:0] cap;
   logic [W-1:0] clr_mask;

   assign adj      = line_s ^ pol_q;
   assign edge_v   = adj & ~prev_q;
   assign cap      = edge_v & en_q;
   assign clr_mask = wr_clr_sel ? wr_data : '0;
   assign req      = |(stat_q & en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr_en_sel)  en_q  <= wr_data;
         if (wr_pol_sel) pol_q <= wr_data;
         prev_q <= adj;
         stat_q <= (stat_q & ~clr_mask) | cap;
      end
   end

   // R5
   disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

   // R3
   set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(cap)) == '0));

   // R7
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(cap) & ~stat_q) == '0));

   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr_sel |=> ((stat_q & $past(wr_data) & ~$past(cap)) == '0));
endmodule

// File: rtl/irqc_dual_bank.sv
module irqc_dual_bank
   import irqc_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0]   irq_lines,
   input  logic                          wr_en,
   input  logic [$clog2(NUM_KINDS*NUM_BANKS)-1:0] wr_addr,
   input  logic [BANK_W-1:0]             wr_data,
   input  logic [$clog2(NUM_KINDS*NUM_BANKS)-1:0] rd_addr,
   output logic [BANK_W-1:0]             rd_data,
   output logic                          host_irq
);
   localparam int NUM_LINES = NUM_BANKS * BANK_W;
   localparam int ADDR_W    = $clog2(NUM_KINDS * NUM_BANKS);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("irqc_dual_bank: NUM_BANKS must be at least 1");
      end
   endgenerate

   logic [NUM_LINES-1:0]                 lines_s;
   logic [NUM_BANKS-1:0][BANK_W-1:0]     en_a;
   logic [NUM_BANKS-1:0][BANK_W-1:0]     pol_a;
   logic [NUM_BANKS-1:0][BANK_W-1:0]     stat_a;
   logic [NUM_BANKS-1:0]                 bank_req;

   irqc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_lines),
      .sync_out (lines_s)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel_en, sel_pol, sel_clr;
         assign sel_en  = wr_en && (wr_addr == ADDR_W'(reg_index(KIND_ENABLE,   b, NUM_BANKS)));
         assign sel_pol = wr_en && (wr_addr == ADDR_W'(reg_index(KIND_POLARITY, b, NUM_BANKS)));
         assign sel_clr = wr_en && (wr_addr == ADDR_W'(reg_index(KIND_STATUS,   b, NUM_BANKS)));

         irqc_bank #(.W(BANK_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_s     (lines_s[b*BANK_W +: BANK_W]),
            .wr_en_sel  (sel_en),
            .wr_pol_sel (sel_pol),
            .wr_clr_sel (sel_clr),
            .wr_data    (wr_data),
            .en_q       (en_a[b]),
            .pol_q      (pol_a[b]),
            .stat_q     (stat_a[b]),
            .req        (bank_req[b])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_addr == ADDR_W'(reg_index(KIND_ENABLE, b, NUM_BANKS)))   rd_data = en_a[b];
         if (rd_addr == ADDR_W'(reg_index(KIND_POLARITY, b, NUM_BANKS))) rd_data = pol_a[b];
         if (rd_addr == ADDR_W'(reg_index(KIND_STATUS, b, NUM_BANKS)))   rd_data = stat_a[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_irq <= 1'b0;
      else        host_irq <= |bank_req;
   end

   // R8
   host_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (host_irq == $past(|(stat_a & en_a))));
endmodule

// File: tb/test_irqc_dual_bank.sv
module test_irqc_dual_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lines = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        host_irq;

   int checks = 0;
   int errors = 0;

   logic [63:0] m_lvl = '0, m_en = '0, m_pol = '0, m_pend = '0;

   always #5 clk = ~clk;

   irqc_dual_bank i_irqc_dual_bank (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .host_irq(host_irq)
   );

   function automatic logic [63:0] hits(logic [63:0] a_old, logic [63:0] a_new, logic [63:0] en);
      return en & ~a_old & a_new;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic check_all(string tag);
      logic [31:0] lo, hi;
      rd(3'd4, lo);
      rd(3'd5, hi);
      check(tag, {hi, lo}, m_pend);
      check({tag, " host"}, 64'(host_irq), 64'(|(m_pend & m_en)));
   endtask

   task automatic set_lines(logic [63:0] v);
      m_pend |= hits(m_lvl ^ m_pol, v ^ m_pol, m_en);
      m_lvl = v;
      @(negedge clk);
      irq_lines = v;
      settle();
   endtask

   task automatic write_en(int b, logic [31:0] v);
      m_en[b*32 +: 32] = v;
      wr(3'(b), v);
      settle();
   endtask

   task automatic write_pol(int b, logic [31:0] v);
      logic [63:0] np;
      np = m_pol;
      np[b*32 +: 32] = v;
      m_pend |= hits(m_lvl ^ m_pol, m_lvl ^ np, m_en);
      m_pol = np;
      wr(3'(2 + b), v);
      settle();
   endtask

   task automatic write_clr(int b, logic [31:0] v);
      m_pend[b*32 +: 32] &= ~v;
      wr(3'(4 + b), v);
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state, R1 unmapped indexes
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         check("R2 reset reg", 64'(d), 64'd0);
      end
      check("R2 reset host", 64'(host_irq), 64'd0);
      rd(3'd6, d); check("R1 unmapped 6", 64'(d), 64'd0);
      rd(3'd7, d); check("R1 unmapped 7", 64'(d), 64'd0);

      // R3 latency on line 5, R8 one cycle later
      m_en[31:0] = 32'hFFFF_FFFF;
      wr(3'd0, 32'hFFFF_FFFF);
      rd_addr = 3'd4;
      @(negedge clk); irq_lines[5] = 1'b1; m_lvl[5] = 1'b1; m_pend[5] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R3 latency edge2", 64'(rd_data[5]), 64'd0);
      @(negedge clk);
      check("R3 latency edge3", 64'(rd_data[5]), 64'd1);
      check("R8 host not yet", 64'(host_irq), 64'd0);
      @(negedge clk);
      check("R8 host raised", 64'(host_irq), 64'd1);
      settle();
      check_all("R3 rising");

      // R1/R3 falling edge on line 40 (high bank bit 8)
      write_pol(1, 32'h0000_0100);
      write_en(1, 32'h0000_0100);
      set_lines(m_lvl | 64'(1) << 40);
      check_all("R3 falling no set on rise");
      set_lines(m_lvl & ~(64'(1) << 40));
      check_all("R1 R3 falling line40");

      // R4 partial clear
      set_lines(m_lvl | 64'h0000_0000_0000_0C00);
      write_clr(0, 32'h0000_0020);
      check_all("R4 partial clear");

      // R5 lost while disabled, R10 enabling at active level
      write_en(0, 32'hFFFF_FF7F);
      set_lines(m_lvl | 64'h80);
      write_en(0, 32'hFFFF_FFFF);
      check_all("R5 R10 disabled edge lost");

      // R6 polarity rewrite of enabled lines
      write_en(1, 32'h0000_0700);
      set_lines(m_lvl | 64'(1) << 42);
      write_clr(1, 32'hFFFF_FFFF);
      write_pol(1, 32'h0000_0700);
      check_all("R6 polarity rewrite");
      check("R6 low line set", 64'(m_pend[41]), 64'd1);

      // R7 edge and clear collide
      write_clr(0, 32'hFFFF_FFFF);
      write_clr(1, 32'hFFFF_FFFF);
      @(negedge clk); irq_lines[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h8;
      @(negedge clk); wr_en = 1'b0;
      m_lvl[3] = 1'b1; m_pend[3] = 1'b1;
      settle();
      check_all("R7 edge wins");

      // R9 disabled pending readable, no request
      write_en(0, 32'h0);
      rd(3'd4, d);
      check("R9 readable", 64'(d[3]), 64'd1);
      check("R9 no host", 64'(host_irq), 64'd0);

      // random mix
      for (int it = 0; it < 300; it++) begin
         int op;
         int b;
         op = int'($urandom_range(0, 3));
         b  = int'($urandom_range(0, 1));
         case (op)
            0: set_lines(m_lvl ^ {$urandom() & $urandom(), $urandom() & $urandom()});
            1: write_en(b, $urandom());
            2: write_pol(b, $urandom() & $urandom());
            default: write_clr(b, $urandom());
         endcase
         check_all("R3 R4 R5 R6 R8 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule